// File: doc/BRIEF.md
# Dual-Channel Scaled Waveform Synthesizer

This block synthesizes periodic waveforms numerically and delivers one narrow DAC code on every clock. Each of its channels has a phase register that steps by a programmable frequency word. The upper phase bits select a point on one of four shapes: sine, triangle, sawtooth or square. The shape value is multiplied by a per-channel amplitude coefficient, which gives a wide scaled sample.

The scaled samples of all channels are added together. The sum is clamped at full scale rather than wrapping. A first-order error accumulator then reduces the sum to the DAC width. The bits below the DAC code are not simply discarded: their carry raises the code by one on some clocks, so the time average of the code follows the full-resolution sum.

The sine values come from a table that is computed at elaboration by an integer function. No memory contents are loaded from outside. A channel can be turned off. While it is off, its phase stays where it is and it adds nothing to the sum.

Top module: `dds_func_gen`

## Requirements
- R1: While a channel's enable is 1, its 32-bit phase increases by its frequency word on every clock, modulo 2^32. Phase bits 31..23 form the 9-bit waveform address `a`.
- R2: When the wave select is 0 (sine), the 9-bit shape value is computed from `h = a mod 256` and `u = h*(256-h)`. First `m = floor(4080*u / (327680 - 4*u))`. The value is then 256+m for a < 256 and 256-m otherwise, so addresses 0, 128 and 384 give 256, 511 and 1.
- R3: When the wave select is 1 (triangle), `t = a` for a < 256 and `t = 511-a` otherwise. The shape value is then 2*(t mod 256).
- R4: When the wave select is 2 (sawtooth), the shape value equals `a`.
- R5: When the wave select is 3 (square), the shape value is 511 when bit 8 of `a` is 0, and 0 otherwise.
- R6: A channel's scaled sample is the 18-bit product of its shape value and its 9-bit amplitude coefficient.
- R7: The scaled samples of both channels are summed. A sum above 262143 is clamped to 262143.
- R8: A 9-bit error register adds bits 8..0 of the clamped sum on every clock, modulo 512. The carry out of that addition is added to bits 17..9 of the sum, with the result held at 511. This result becomes the DAC code at the clock edge. The code visible after an edge is therefore computed from the phases and inputs present before that edge.
- R9: While a channel's enable is 0, its phase holds and its contribution to the sum is 0. With both channels off, the code is 0 from the next edge.
- R10: An active-low asynchronous reset clears both phases, the error register and the DAC code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_en | input | 2 | Per-channel enable (bit 0 = channel 0) |
| freq_word | input | 2x32 | Per-channel phase increment |
| wave_sel | input | 2x2 | Per-channel shape: 0 sine, 1 triangle, 2 sawtooth, 3 square |
| amp_coef | input | 2x9 | Per-channel amplitude coefficient |
| dac_code | output | 9 | Dithered DAC code, registered |

## Verification
Clamping of the channel sum and the dither carry can land on the same clock. When the sum sits at 262143, its low bits are all ones, so the error register produces a carry on almost every clock. That carry must then be absorbed by the hold at 511 rather than wrapping the code to 0. The bench provokes this by driving both channels as full-amplitude squares at phase zero for several clocks. It judges the result by requiring a code of exactly 511 on every one of those clocks. A reference model also follows the same collision inside the vector runs, where the squares of both channels overlap.

// File: rtl/dds_pkg.sv
package dds_pkg;
   typedef enum logic [1:0] {
      WAVE_SINE   = 2'd0,
      WAVE_TRI    = 2'd1,
      WAVE_SAW    = 2'd2,
      WAVE_SQUARE = 2'd3
   } wave_e;
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
   parameter int PHASE_W = 32,
   parameter int ADDR_W  = 9
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic [PHASE_W-1:0] freq,
   output logic [PHASE_W-1:0] phase,
   output logic [ADDR_W-1:0]  addr
);
   if (ADDR_W > PHASE_W) begin : g_bad_addr
      $error("dds_phase_acc: ADDR_W exceeds PHASE_W");
   end

   // R1: modular advance; R9: hold while disabled; R10: cleared by reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  phase <= '0;
      else if (en) phase <= phase + freq;
   end

   assign addr = phase[PHASE_W-1 -: ADDR_W];
endmodule

// File: rtl/dds_wave_shaper.sv
module dds_wave_shaper
   import dds_pkg::*;
#(
   parameter int ADDR_W = 9,
   parameter int AMP_W  = 9
) (
   input  wave_e             sel,
   input  logic [ADDR_W-1:0] addr,
   output logic [AMP_W-1:0]  amp
);
   localparam int    N_PTS  = 1 << ADDR_W;
   localparam int    HALF   = N_PTS / 2;
   localparam longint MID   = longint'(1) << (AMP_W - 1);
   localparam longint MAXMG = MID - 1;

   if (AMP_W != ADDR_W) begin : g_bad_width
      $error("dds_wave_shaper: AMP_W must equal ADDR_W");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("dds_wave_shaper: ADDR_W too small");
   end

   typedef logic [AMP_W-1:0] lut_t [N_PTS];

   // Rational half-wave approximation evaluated once at elaboration (R2)
   function automatic lut_t build_sine();
      lut_t   t;
      longint h, u, mg;
      for (int i = 0; i < N_PTS; i++) begin
         h  = longint'(i % HALF);
         u  = h * (longint'(HALF) - h);
         mg = (MAXMG * 16 * u) / (5 * longint'(HALF) * longint'(HALF) - 4 * u);
         t[i] = (i < HALF) ? AMP_W'(MID + mg) : AMP_W'(MID - mg);
      end
      return t;
   endfunction

   localparam lut_t SINE_LUT = build_sine();

   logic [ADDR_W-1:0] folded;
   assign folded = addr[ADDR_W-1] ? ~addr : addr;

   always_comb begin
      case (sel)
         WAVE_SINE:   amp = SINE_LUT[addr];                         // R2
         WAVE_TRI:    amp = {folded[ADDR_W-2:0], 1'b0};              // R3
         WAVE_SAW:    amp = addr;                                   // R4
         default:     amp = addr[ADDR_W-1] ? '0 : '1;               // R5
      endcase
   end
endmodule

// File: rtl/dds_dither.sv
module dds_dither #(
   parameter int SUM_W     = 18,
   parameter int DAC_W     = 9,
   parameter bit DITHER_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SUM_W-1:0] sample,
   output logic [DAC_W-1:0] code
);
   localparam int LOW_W = SUM_W - DAC_W;
   localparam logic [DAC_W-1:0] CODE_MAX = '1;

   if (LOW_W < 1) begin : g_bad_width
      $error("dds_dither: SUM_W must exceed DAC_W");
   end

   logic [DAC_W-1:0] top;
   logic             carry;
   logic [DAC_W:0]   bumped;
   logic [DAC_W-1:0] code_nxt;

   assign top = sample[SUM_W-1 -: DAC_W];

   if (DITHER_EN) begin : g_dither
      logic [LOW_W-1:0] err_q;
      logic [LOW_W:0]   err_sum;
      assign err_sum = {1'b0, err_q} + {1'b0, sample[LOW_W-1:0]};
      assign carry   = err_sum[LOW_W];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) err_q <= '0;
         else        err_q <= err_sum[LOW_W-1:0];
      end
   end else begin : g_trunc
      logic unused_low;
      assign unused_low = ^sample[LOW_W-1:0];
      assign carry      = 1'b0;
   end

   // R8: carry raises the code, held at full scale
   assign bumped   = {1'b0, top} + {{DAC_W{1'b0}}, carry};
   assign code_nxt = bumped[DAC_W] ? CODE_MAX : bumped[DAC_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code <= '0;
      else        code <= code_nxt;
   end
endmodule

// File: rtl/dds_func_gen.sv
module dds_func_gen
   import dds_pkg::*;
#(
   parameter int NCH       = 2,
   parameter int PHASE_W   = 32,
   parameter int ADDR_W    = 9,
   parameter int AMP_W     = 9,
   parameter int COEF_W    = 9,
   parameter int DAC_W     = 9,
   parameter bit DITHER_EN = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NCH-1:0]                ch_en,
   input  logic [NCH-1:0][PHASE_W-1:0]   freq_word,
   input  logic [NCH-1:0][1:0]           wave_sel,
   input  logic [NCH-1:0][COEF_W-1:0]    amp_coef,
   output logic [DAC_W-1:0]              dac_code
);
   localparam int SCALE_W = AMP_W + COEF_W;
   localparam int ACC_W   = SCALE_W + $clog2(NCH + 1);
   localparam logic [ACC_W-1:0] SAT_MAX = ACC_W'({SCALE_W{1'b1}});

   if (NCH < 1) begin : g_bad_nch
      $error("dds_func_gen: NCH must be at least 1");
   end
   if (DAC_W >= SCALE_W) begin : g_bad_dac
      $error("dds_func_gen: DAC_W must be narrower than the scaled sample");
   end

   logic [NCH-1:0][PHASE_W-1:0] phase_q;
   logic [SCALE_W-1:0]          scaled [NCH];
   logic [ACC_W-1:0]            acc;
   logic [SCALE_W-1:0]          sum_sat;

   for (genvar g = 0; g < NCH; g++) begin : g_chan
      logic [ADDR_W-1:0] addr;
      logic [AMP_W-1:0]  amp;

      dds_phase_acc #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) i_phase (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (ch_en[g]),
         .freq  (freq_word[g]),
         .phase (phase_q[g]),
         .addr  (addr)
      );

      dds_wave_shaper #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) i_shape (
         .sel  (wave_e'(wave_sel[g])),
         .addr (addr),
         .amp  (amp)
      );

      // R6 product; R9 zero contribution while disabled
      assign scaled[g] = ch_en[g] ? SCALE_W'(amp) * SCALE_W'(amp_coef[g]) : '0;
   end

   // R7: wide sum, clamped at the scaled full scale
   always_comb begin
      acc = '0;
      for (int c = 0; c < NCH; c++) acc = acc + ACC_W'(scaled[c]);
   end
   assign sum_sat = (acc > SAT_MAX) ? SAT_MAX[SCALE_W-1:0] : acc[SCALE_W-1:0];

   dds_dither #(.SUM_W(SCALE_W), .DAC_W(DAC_W), .DITHER_EN(DITHER_EN)) i_dither (
      .clk    (clk),
      .rst_n  (rst_n),
      .sample (sum_sat),
      .code   (dac_code)
   );
endmodule

// File: rtl/dds_func_gen_chk.sv
module dds_func_gen_chk #(
   parameter int NCH     = 2,
   parameter int PHASE_W = 32,
   parameter int SCALE_W = 18,
   parameter int DAC_W   = 9
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [NCH-1:0]              ch_en,
   input logic [NCH-1:0][PHASE_W-1:0] freq_word,
   input logic [NCH-1:0][PHASE_W-1:0] phase_q,
   input logic [SCALE_W-1:0]          sum_sat,
   input logic [DAC_W-1:0]            dac_code
);
   localparam logic [DAC_W-1:0]   CODE_MAX = '1;
   localparam logic [SCALE_W-1:0] SUM_MAX  = '1;

   logic             past_ok;
   logic [DAC_W-1:0] top;
   assign top = sum_sat[SCALE_W-1 -: DAC_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
         past_ok && ch_en[g] |=> phase_q[g] == $past(phase_q[g]) + $past(freq_word[g]));
      p_phase_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
         past_ok && !ch_en[g] |=> $stable(phase_q[g]));
   end

   p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && (ch_en == '0) |=> dac_code == '0);

   p_dither_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |=> (dac_code == $past(top)) ||
                  ({1'b0, dac_code} == {1'b0, $past(top)} + 1'b1));

   p_full_scale_r7: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && (sum_sat == SUM_MAX) |=> dac_code == CODE_MAX);
endmodule

bind dds_func_gen dds_func_gen_chk #(
   .NCH     (NCH),
   .PHASE_W (PHASE_W),
   .SCALE_W (SCALE_W),
   .DAC_W   (DAC_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ch_en     (ch_en),
   .freq_word (freq_word),
   .phase_q   (phase_q),
   .sum_sat   (sum_sat),
   .dac_code  (dac_code)
);

// File: tb/test_dds_func_gen.sv
module test_dds_func_gen;
   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [1:0]       ch_en = '0;
   logic [1:0][31:0] freq_word = '0;
   logic [1:0][1:0]  wave_sel = '0;
   logic [1:0][8:0]  amp_coef = '0;
   logic [8:0]       dac_code;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   logic [31:0] m_phase [2];
   int m_err;
   int m_dac;

   always #10 clk = ~clk;   // 50 MHz

   dds_func_gen i_dds_func_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .ch_en     (ch_en),
      .freq_word (freq_word),
      .wave_sel  (wave_sel),
      .amp_coef  (amp_coef),
      .dac_code  (dac_code)
   );

   typedef struct packed {
      logic [1:0]  en;
      logic [1:0]  wa;
      logic [1:0]  wb;
      logic [8:0]  ca;
      logic [8:0]  cb;
      logic [31:0] fa;
      logic [31:0] fb;
      logic [15:0] n;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{2'b01, 2'd0, 2'd0, 9'd511, 9'd0,   32'h0100_0000, 32'h0,         16'd300}, // R2 sine, R6
      '{2'b11, 2'd1, 2'd2, 9'd300, 9'd200, 32'h0123_4567, 32'h02F0_0001, 16'd300}, // R3 R4 mixed
      '{2'b11, 2'd3, 2'd3, 9'd511, 9'd511, 32'h0080_0000, 32'h00C0_0000, 16'd300}, // R5 R7 overlap
      '{2'b11, 2'd2, 2'd0, 9'd0,   9'd77,  32'h0400_0000, 32'h0311_0000, 16'd300}, // R6 zero coef
      '{2'b10, 2'd0, 2'd3, 9'd400, 9'd123, 32'h0500_0000, 32'h0077_7777, 16'd300}, // R9 A off
      '{2'b00, 2'd1, 2'd1, 9'd511, 9'd511, 32'h1234_5678, 32'h0FED_CBA9, 16'd50},  // R9 both off
      '{2'b11, 2'd0, 2'd0, 9'd389, 9'd250, 32'h3777_1234, 32'hF00F_0F0F, 16'd300}, // R1 wrap
      '{2'b11, 2'd1, 2'd1, 9'd256, 9'd255, 32'h00A0_0000, 32'h0110_0000, 16'd300}  // R3 R8
   };

   function automatic int wave_val(int sel, int a);
      int h, u, m, t;
      case (sel)
         0: begin
            h = a % 256;
            u = h * (256 - h);
            m = (4080 * u) / (327680 - 4 * u);
            return (a < 256) ? 256 + m : 256 - m;
         end
         1: begin
            t = (a < 256) ? a : 511 - a;
            return 2 * (t % 256);
         end
         2: return a;
         default: return (a < 256) ? 511 : 0;
      endcase
   endfunction

   task automatic model_step();
      int sum, e, carry, top;
      sum = 0;
      for (int c = 0; c < 2; c++)
         if (ch_en[c]) sum += wave_val(int'(wave_sel[c]), int'(m_phase[c][31:23])) * int'(amp_coef[c]);
      if (sum > 262143) sum = 262143;
      top   = sum / 512;
      e     = m_err + (sum % 512);
      carry = (e >= 512) ? 1 : 0;
      m_err = e % 512;
      m_dac = (top + carry > 511) ? 511 : top + carry;
      for (int c = 0; c < 2; c++)
         if (ch_en[c]) m_phase[c] = m_phase[c] + freq_word[c];
   endtask

   task automatic check(bit ok, string req, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(string req);
      @(posedge clk);
      model_step();
      @(negedge clk);
      check(int'(dac_code) == m_dac, req, int'(dac_code), m_dac);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      m_phase[0] = '0;
      m_phase[1] = '0;
      m_err = 0;
      m_dac = 0;
      repeat (2) @(negedge clk);
      check(dac_code == 9'd0, "R10 code in reset", int'(dac_code), 0);
      rst_n = 1'b1;
   endtask

   task automatic set_ch(int c, bit en, int sel, int coef, logic [31:0] f);
      ch_en[c]     = en;
      wave_sel[c]  = 2'(sel);
      amp_coef[c]  = 9'(coef);
      freq_word[c] = f;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int acc;
      m_phase[0] = '0;
      m_phase[1] = '0;
      m_err = 0;
      m_dac = 0;
      repeat (3) @(negedge clk);
      check(dac_code == 9'd0, "R10 initial code", int'(dac_code), 0);
      rst_n = 1'b1;

      // vector table walk against the reference model
      for (int v = 0; v < 8; v++) begin
         set_ch(0, VECS[v].en[0], int'(VECS[v].wa), int'(VECS[v].ca), VECS[v].fa);
         set_ch(1, VECS[v].en[1], int'(VECS[v].wb), int'(VECS[v].cb), VECS[v].fb);
         for (int k = 0; k < int'(VECS[v].n); k++) begin
            tick("R6 R8 vector model");
            if (VECS[v].en == 2'b00)
               check(dac_code == 9'd0, "R9 both channels off", int'(dac_code), 0);
         end
      end

      // R2: sine at addresses 0,128,256,384, full coefficient
      do_reset();
      set_ch(0, 1, 0, 511, 32'h4000_0000);
      set_ch(1, 0, 0, 0, 32'h0);
      tick("R2 sine a=0");   check(dac_code == 9'd255, "R2 sine a=0",   int'(dac_code), 255);
      tick("R2 sine a=128"); check(dac_code == 9'd510, "R2 sine a=128", int'(dac_code), 510);
      tick("R2 sine a=256"); check(dac_code == 9'd256, "R2 sine a=256", int'(dac_code), 256);
      tick("R2 sine a=384"); check(dac_code == 9'd1,   "R2 sine a=384", int'(dac_code), 1);

      // R7: both full squares, clamp collides with dither carry
      do_reset();
      set_ch(0, 1, 3, 511, 32'h0);
      set_ch(1, 1, 3, 511, 32'h0);
      for (int k = 0; k < 6; k++) begin
         tick("R7 saturated model");
         check(dac_code == 9'd511, "R7 clamp at full scale", int'(dac_code), 511);
      end

      // R8: sum of 511 averages to 511/512 over 512 clocks
      do_reset();
      set_ch(0, 1, 3, 1, 32'h0);
      set_ch(1, 0, 3, 1, 32'h0);
      acc = 0;
      for (int k = 0; k < 512; k++) begin
         tick("R8 dither model");
         if (k == 0) check(dac_code == 9'd0, "R8 first carry-free clock", int'(dac_code), 0);
         if (k == 1) check(dac_code == 9'd1, "R8 first carry", int'(dac_code), 1);
         acc += int'(dac_code);
      end
      check(acc == 511, "R8 average over 512 clocks", acc, 511);

      // R5 R9: disable mid-run, phase held, then resume
      do_reset();
      set_ch(0, 1, 2, 511, 32'h0300_0000);
      set_ch(1, 1, 3, 100, 32'h0900_0000);
      repeat (20) tick("R4 R5 pre-hold");
      ch_en = 2'b00;
      repeat (10) begin
         tick("R9 hold");
         check(dac_code == 9'd0, "R9 disabled output", int'(dac_code), 0);
      end
      ch_en = 2'b11;
      repeat (40) tick("R9 resume from held phase");

      // R10: reset in the middle of activity
      do_reset();
      ch_en = 2'b00;
      tick("R10 after reset");

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule